// File: doc/BRIEF.md
# Dual-Rate Clock Enable Controller

This block runs from one oscillator clock and produces three registered clock enables: one for the CPU core, one for the peripheral group (timers, card interface, ADC, SPI, port sampling) and one for the PLL reference path. A single mode bit sets the rate of both the CPU and the peripheral enables. In standard mode they pulse on every second oscillator cycle, which gives 12 oscillator periods per machine cycle. In double-speed mode they pulse on every oscillator cycle, which gives 6.

The mode bit is loaded from a fuse input while reset is asserted, and software can rewrite it afterwards. A change of mode takes effect only at the end of a divider phase pair, so the enable pattern never breaks a half-rate period. Two power bits gate the enables. The sleep bit stops the CPU enable only. The halt bit stops all three. An interrupt pulse clears the sleep bit, and a separate wake pulse clears the halt bit.

Downstream logic qualifies its flops with these enables on the oscillator clock, so no derived clock net exists. The block has no data stream. Its control and status pins are plain levels and single-cycle pulses.

Top module: `dualrate_clk_ctrl`

## Requirements
- R1: In standard mode (mode bit 0), with no gating, `per_ce` and `cpu_ce` are high on exactly every second oscillator cycle: 10 of any 20 consecutive cycles, never two cycles in a row.
- R2: In double-speed mode (mode bit 1), with no gating, `per_ce` and `cpu_ce` are high on every oscillator cycle.
- R3: A write with `wr_sel`=0 stores `wr_data[0]` as the requested mode. `mode_eff` follows the request within two cycles, and the rate of both CPU and peripheral enables follows `mode_eff`.
- R4: While `arst_n` is low, `mode_eff` takes the value of `fuse_fast`. After reset, changes on `fuse_fast` have no effect on `mode_eff`.
- R5: `mode_eff` changes only on the edge that closes a divider phase pair, so no enable gap is cut short.
- R6: A write with `wr_sel`=1 stores `wr_data[0]` as the sleep bit (`sleep_q`). While it is set, `cpu_ce` stays low and `per_ce` and `pll_ce` keep running.
- R7: The same write stores `wr_data[1]` as the halt bit (`halt_q`). While it is set, `cpu_ce`, `per_ce` and `pll_ce` all stay low.
- R8: A pulse on `irq_wake` clears the sleep bit on the next edge and leaves the halt bit unchanged.
- R9: A pulse on `halt_wake` clears the halt bit on the next edge, after which the enables resume at the current rate.
- R10: Reset drives all enables low and clears both power bits. Outside reset, `pll_ce` is high on every cycle unless the halt bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| fuse_fast | input | 1 | Boot-mode fuse, 1 selects double-speed after reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 mode, 1 power |
| wr_data | input | 8 | Write data |
| irq_wake | input | 1 | External interrupt pulse, clears sleep |
| halt_wake | input | 1 | External wake pulse, clears halt |
| cpu_ce | output | 1 | CPU core clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| pll_ce | output | 1 | PLL reference enable |
| mode_eff | output | 1 | Mode in effect, 1 = double-speed |
| sleep_q | output | 1 | Sleep bit |
| halt_q | output | 1 | Halt bit |

## Verification
A divider phase stuck or out of step shows up within two cycles as `per_ce` holding still or pulsing on adjacent cycles in standard mode. A mode register that latches late or early shows as `mode_eff` flipping off a phase boundary, or as a wrong enable count within a 20-cycle window. Power bits that are decoded wrongly or fail to clear show up on the next edge as an enable that should run or stop, or as a status bit that does not clear after a wake pulse.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef enum logic {SEL_MODE = 1'b0, SEL_POWER = 1'b1} reg_sel_e;
  localparam int NUM_CE = 3;
  localparam int CE_CPU = 0;
  localparam int CE_PER = 1;
  localparam int CE_PLL = 2;
  typedef struct packed {
    logic rated;
    logic stop_sleep;
    logic stop_halt;
  } ce_policy_t;
endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs #(
  parameter int DATA_W    = 8,
  parameter int MODE_BIT  = 0,
  parameter int SLEEP_BIT = 0,
  parameter int HALT_BIT  = 1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              fuse_fast,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_wake,
  input  logic              halt_wake,
  output logic              mode_req,
  output logic              sleep_q,
  output logic              halt_q
);
  import clkctl_pkg::*;

  logic wr_mode, wr_pwr;
  assign wr_mode = wr_en && (reg_sel_e'(wr_sel) == SEL_MODE);
  assign wr_pwr  = wr_en && (reg_sel_e'(wr_sel) == SEL_POWER);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode_req <= fuse_fast;
    end else if (wr_mode) begin
      mode_req <= wr_data[MODE_BIT];
    end
  end

  // wake pulses take priority over a simultaneous write
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sleep_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      if (irq_wake)    sleep_q <= 1'b0;
      else if (wr_pwr) sleep_q <= wr_data[SLEEP_BIT];
      if (halt_wake)   halt_q  <= 1'b0;
      else if (wr_pwr) halt_q  <= wr_data[HALT_BIT];
    end
  end
endmodule

// File: rtl/clkctl_divider.sv
module clkctl_divider (
  input  logic clk,
  input  logic arst_n,
  input  logic fuse_fast,
  input  logic mode_req,
  output logic phase_q,
  output logic mode_eff,
  output logic tick
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  // the mode only changes on the edge that closes a phase pair
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      mode_eff <= fuse_fast;
    else if (phase_q) mode_eff <= mode_req;
  end

  assign tick = mode_eff | phase_q;
endmodule

// File: rtl/clkctl_gate.sv
module clkctl_gate #(
  parameter int NUM = clkctl_pkg::NUM_CE
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           tick,
  input  logic           sleep_q,
  input  logic           halt_q,
  output logic [NUM-1:0] ce_q
);
  import clkctl_pkg::*;

  function automatic ce_policy_t policy(input int idx);
    ce_policy_t p;
    p.rated      = (idx != CE_PLL);
    p.stop_sleep = (idx == CE_CPU);
    p.stop_halt  = 1'b1;
    return p;
  endfunction

  for (genvar g = 0; g < NUM; g++) begin : g_ce
    localparam ce_policy_t P = policy(g);
    logic run;
    assign run = (P.rated ? tick : 1'b1)
               & ~(P.stop_sleep & sleep_q)
               & ~(P.stop_halt & halt_q);
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) ce_q[g] <= 1'b0;
      else         ce_q[g] <= run;
    end
  end
endmodule

// File: rtl/dualrate_clk_ctrl.sv
module dualrate_clk_ctrl #(
  parameter int DATA_W    = 8,
  parameter int MODE_BIT  = 0,
  parameter int SLEEP_BIT = 0,
  parameter int HALT_BIT  = 1
) (
  input  logic              osc_clk,
  input  logic              arst_n,
  input  logic              fuse_fast,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_wake,
  input  logic              halt_wake,
  output logic              cpu_ce,
  output logic              per_ce,
  output logic              pll_ce,
  output logic              mode_eff,
  output logic              sleep_q,
  output logic              halt_q
);
  import clkctl_pkg::*;

  logic mode_req, phase_q, tick;
  logic [NUM_CE-1:0] ce_q;

  clkctl_regs #(
    .DATA_W(DATA_W), .MODE_BIT(MODE_BIT),
    .SLEEP_BIT(SLEEP_BIT), .HALT_BIT(HALT_BIT)
  ) u_regs (
    .clk(osc_clk), .arst_n(arst_n), .fuse_fast(fuse_fast),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_wake(irq_wake), .halt_wake(halt_wake),
    .mode_req(mode_req), .sleep_q(sleep_q), .halt_q(halt_q)
  );

  clkctl_divider u_div (
    .clk(osc_clk), .arst_n(arst_n), .fuse_fast(fuse_fast),
    .mode_req(mode_req), .phase_q(phase_q), .mode_eff(mode_eff), .tick(tick)
  );

  clkctl_gate #(.NUM(NUM_CE)) u_gate (
    .clk(osc_clk), .arst_n(arst_n), .tick(tick),
    .sleep_q(sleep_q), .halt_q(halt_q), .ce_q(ce_q)
  );

  assign cpu_ce = ce_q[CE_CPU];
  assign per_ce = ce_q[CE_PER];
  assign pll_ce = ce_q[CE_PLL];
endmodule

// File: rtl/clkctl_checker.sv
module clkctl_checker (
  input logic osc_clk,
  input logic arst_n,
  input logic phase_q,
  input logic mode_eff,
  input logic cpu_ce,
  input logic per_ce,
  input logic pll_ce,
  input logic sleep_q,
  input logic halt_q,
  input logic irq_wake,
  input logic halt_wake
);
  logic up;
  always_ff @(posedge osc_clk or negedge arst_n) begin
    if (!arst_n) up <= 1'b0;
    else         up <= 1'b1;
  end

  assert_std_alternate_R1: assert property (@(posedge osc_clk) disable iff (!arst_n)
    (up && !mode_eff && !$past(mode_eff) && per_ce) |=> !per_ce);

  assert_fast_rate_R2: assert property (@(posedge osc_clk) disable iff (!arst_n)
    (up && $past(up) && $past(mode_eff) && !$past(halt_q)) |-> (per_ce && ($past(sleep_q) || cpu_ce)));

  assert_mode_boundary_R5: assert property (@(posedge osc_clk) disable iff (!arst_n)
    (up && !$stable(mode_eff)) |-> $past(phase_q));

  assert_sleep_cpu_R6: assert property (@(posedge osc_clk) disable iff (!arst_n)
    (up && $past(up) && $past(sleep_q)) |-> !cpu_ce);

  assert_halt_all_R7: assert property (@(posedge osc_clk) disable iff (!arst_n)
    (up && $past(up) && $past(halt_q)) |-> !(cpu_ce || per_ce || pll_ce));

  assert_irq_clear_R8: assert property (@(posedge osc_clk) disable iff (!arst_n)
    (up && irq_wake) |=> !sleep_q);

  assert_halt_clear_R9: assert property (@(posedge osc_clk) disable iff (!arst_n)
    (up && halt_wake) |=> !halt_q);

  assert_pll_run_R10: assert property (@(posedge osc_clk) disable iff (!arst_n)
    (up && $past(up) && !$past(halt_q)) |-> pll_ce);
endmodule

bind dualrate_clk_ctrl clkctl_checker u_chk (
  .osc_clk(osc_clk), .arst_n(arst_n), .phase_q(phase_q), .mode_eff(mode_eff),
  .cpu_ce(cpu_ce), .per_ce(per_ce), .pll_ce(pll_ce), .sleep_q(sleep_q),
  .halt_q(halt_q), .irq_wake(irq_wake), .halt_wake(halt_wake)
);

// File: tb/sim_dualrate_clk_ctrl.sv
`timescale 1ns/1ps
module sim_dualrate_clk_ctrl;
  logic       osc_clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       fuse_fast = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq_wake = 1'b0;
  logic       halt_wake = 1'b0;
  logic       cpu_ce, per_ce, pll_ce, mode_eff, sleep_q, halt_q;

  int n_total = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 osc_clk = ~osc_clk;

  dualrate_clk_ctrl u0 (
    .osc_clk(osc_clk), .arst_n(arst_n), .fuse_fast(fuse_fast),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_wake(irq_wake), .halt_wake(halt_wake),
    .cpu_ce(cpu_ce), .per_ce(per_ce), .pll_ce(pll_ce),
    .mode_eff(mode_eff), .sleep_q(sleep_q), .halt_q(halt_q)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge osc_clk);
  endtask

  task automatic do_reset(input bit fuse);
    @(negedge osc_clk);
    arst_n = 1'b0;
    fuse_fast = fuse;
    step(3);
    arst_n = 1'b1;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge osc_clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic count(input int n, output int c_cpu, output int c_per,
                       output int c_pll, output int adj_per);
    logic prev = 1'b0;
    c_cpu = 0; c_per = 0; c_pll = 0; adj_per = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge osc_clk);
      c_cpu += int'(cpu_ce);
      c_per += int'(per_ce);
      c_pll += int'(pll_ce);
      if (prev && per_ce) adj_per++;
      prev = per_ce;
    end
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    arst_n = 1'b0;
    #1;
    check(!cpu_ce && !per_ce && !pll_ce, "R10 enables low in reset", int'({cpu_ce, per_ce, pll_ce}), 0);
    check(!sleep_q && !halt_q, "R10 power bits clear in reset", int'({sleep_q, halt_q}), 0);
    check(mode_eff == 1'b0, "R4 fuse 0 gives standard mode", int'(mode_eff), 0);
    arst_n = 1'b1;
  endtask

  task automatic t_std_rate;
    int c, p, l, a;
    step(4);
    count(20, c, p, l, a);
    check(p == 10, "R1 per_ce count std", p, 10);
    check(c == 10, "R1 cpu_ce count std", c, 10);
    check(a == 0, "R1 no adjacent per_ce std", a, 0);
    check(l == 20, "R10 pll_ce runs", l, 20);
  endtask

  task automatic t_fast_rate;
    int c, p, l, a;
    wr(1'b0, 8'h01);
    step(2);
    check(mode_eff == 1'b1, "R3 mode follows write within two cycles", int'(mode_eff), 1);
    step(2);
    count(20, c, p, l, a);
    check(p == 20, "R2 per_ce count fast", p, 20);
    check(c == 20, "R2 cpu_ce count fast", c, 20);
  endtask

  task automatic t_switch_back;
    int c, p, l, a;
    wr(1'b0, 8'hFE);
    while (mode_eff) @(negedge osc_clk);
    count(20, c, p, l, a);
    check(a == 0, "R5 no short gap after switch to std", a, 0);
    check(p == 10, "R3 per_ce std after switch", p, 10);
  endtask

  task automatic t_fuse_ignored;
    fuse_fast = 1'b1;
    step(6);
    check(mode_eff == 1'b0, "R4 fuse ignored after reset", int'(mode_eff), 0);
    fuse_fast = 1'b0;
  endtask

  task automatic t_sleep;
    int c, p, l, a;
    wr(1'b1, 8'hFD);
    check(sleep_q && !halt_q, "R6 sleep bit set", int'({sleep_q, halt_q}), 2);
    step(2);
    count(20, c, p, l, a);
    check(c == 0, "R6 cpu_ce stopped in sleep", c, 0);
    check(p == 10, "R6 per_ce runs in sleep", p, 10);
    check(l == 20, "R6 pll_ce runs in sleep", l, 20);
  endtask

  task automatic t_halt_and_wake;
    int c, p, l, a;
    wr(1'b1, 8'h03);
    step(2);
    count(20, c, p, l, a);
    check(c + p + l == 0, "R7 all enables stopped in halt", c + p + l, 0);
    irq_wake = 1'b1;
    @(negedge osc_clk);
    irq_wake = 1'b0;
    check(!sleep_q, "R8 irq clears sleep", int'(sleep_q), 0);
    check(halt_q, "R8 irq leaves halt", int'(halt_q), 1);
    count(10, c, p, l, a);
    check(c + p + l == 0, "R8 still halted after irq", c + p + l, 0);
    halt_wake = 1'b1;
    @(negedge osc_clk);
    halt_wake = 1'b0;
    check(!halt_q, "R9 wake clears halt", int'(halt_q), 0);
    step(2);
    count(20, c, p, l, a);
    check(p == 10 && c == 10 && l == 20, "R9 enables resume", p + c + l, 40);
  endtask

  task automatic t_fuse_boot;
    int c, p, l, a;
    do_reset(1'b1);
    check(mode_eff == 1'b1, "R4 fuse 1 boots double-speed", int'(mode_eff), 1);
    step(2);
    count(20, c, p, l, a);
    check(p == 20, "R2 per_ce fast after fuse boot", p, 20);
  endtask

  initial begin
    t_reset_state();
    t_std_rate();
    t_fast_rate();
    t_switch_back();
    t_fuse_ignored();
    t_sleep();
    t_halt_and_wake();
    t_fuse_boot();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule